// File: doc/BRIEF.md
# Dual-Context Byte-Stream DMA Channel

This block is one DMA channel that carries a stream of bytes between system memory and a byte-wide peripheral, such as a printer port. Software describes each buffer with a 64-bit descriptor. Two descriptor slots, A and B, are available. Software hands a slot to hardware by setting that slot's valid bit. The channel runs the valid slots in alternation, so software can refill one buffer while the other one drains.

The memory side is a single request/ready port that moves one byte per accepted request and can return an error response. The peripheral side is a byte-wide valid/ready stream in each direction. A one-entry holding register sits between the two sides.

Software sees a control/status word and a diagnostic word. The diagnostic word shows the slot in use, whether the engine is running, and how many bytes are still outstanding. There are three sticky interrupt flags: slot A done, slot B done, and memory error. When a buffer that is marked as the last one has fully drained, the channel drives a one-cycle terminal-count strobe to the device.

Top module: `dma_pingpong_chan`

## Requirements
- R1: After `rstN` is low, `ctrlStatus` and `diagStatus` read 0, all three interrupt outputs are 0, `termCount` is 0 and no memory request is made.
- R2: A write with `regSel`=0 loads slot A and a write with `regSel`=1 loads slot B. In the descriptor, bits 31:0 are the base address, bits 43:32 are the 12-bit byte length and bit 63 is the last flag. With direction 0 (memory to device), the channel reads `len` bytes from consecutive addresses and delivers them on `txData` in address order.
- R3: With direction 1 (device to memory), the channel accepts `len` bytes on `rxData` and writes them to consecutive addresses in arrival order. In this direction the low 6 bits of the base are treated as zero.
- R4: Addresses advance only inside the 4096-byte page of the base. The low 12 bits wrap from 0xFFF to 0x000 and bits 31:12 keep the base's value.
- R5: `termCount` pulses high for exactly one cycle when a slot whose last flag is 1 completes. A slot whose last flag is 0 produces no pulse.
- R6: A control write (`regSel`=2) with bit 4 set marks slot A valid, and one with bit 3 set marks slot B valid. Writing 0 to either bit leaves that valid bit unchanged. Hardware clears a slot's valid bit when the slot completes. `ctrlStatus` reports the valid bits at the same positions and reports direction, enable and reset at bits 0, 1 and 2.
- R7: After reset the channel starts with slot A. When a slot completes, the channel moves to the other slot. If the other slot is not valid, the channel waits idle. From idle it starts the other slot first if that slot is valid, and otherwise the slot it just finished, once that slot is made valid again.
- R8: Clearing the enable bit (control bit 1) freezes the channel. No byte moves, the remaining count holds and the valid bits are kept. Setting the bit again resumes the transfer, which then completes with every byte intact.
- R9: While control bit 2 is 1, the channel is held in reset. Both valid bits read 0 and valid-bit writes are ignored. The remaining count reads 0, no memory or device traffic occurs, and the next transfer starts with slot A.
- R10: `diagStatus` bit 0 shows the slot in use (0 = A, 1 = B). Bit 1 is 1 when the channel is enabled and working on a slot. Bits 13:2 hold the bytes not yet read from memory (direction 0) or not yet written to memory (direction 1).
- R11: The done flags `irqDoneA` and `irqDoneB` are sticky and are set when their slot completes. A write with `regSel`=3 clears flags by writing 1s: bit 0 clears done A, bit 1 clears done B and bit 2 clears the memory-error flag.
- R12: A memory response with `memError` set stops the channel. The enable bit is cleared, `irqMemError` is set, the remaining count is not decremented and the failed byte is neither delivered nor counted.
- R13: A slot with length 0 completes without any memory access and sets its done flag. It pulses `termCount` if its last flag is 1.
- R14: A memory request keeps its address and write data stable until `memReady`. No new memory read starts while the holding register still holds a byte the device has not taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 2 | 0 slot A, 1 slot B, 2 control, 3 flag clear |
| regWrData | input | 64 | Register write data |
| ctrlStatus | output | 5 | {validA, validB, reset, enable, direction} |
| diagStatus | output | 14 | {remaining[11:0], running, slotInUse} |
| irqDoneA | output | 1 | Sticky slot A done flag |
| irqDoneB | output | 1 | Sticky slot B done flag |
| irqMemError | output | 1 | Sticky memory error flag |
| termCount | output | 1 | One-cycle strobe after a last buffer drains |
| memReq | output | 1 | Memory request |
| memWrite | output | 1 | 1 for a write request, 0 for a read |
| memAddr | output | 32 | Byte address |
| memWrData | output | 8 | Write data |
| memReady | input | 1 | Request accepted and completed this cycle |
| memRdData | input | 8 | Read data, valid with memReady |
| memError | input | 1 | Error response, valid with memReady |
| txValid | output | 1 | Byte offered to the device |
| txData | output | 8 | Byte to the device |
| txReady | input | 1 | Device takes the byte |
| rxValid | input | 1 | Device offers a byte |
| rxData | input | 8 | Byte from the device |
| rxReady | output | 1 | Channel takes the byte |

## Verification
The bench runs these corner cases:

- **Page wrap.** A buffer starts 16 bytes below a page boundary. A design that carries into bit 12 fetches the wrong second half.
- **Input alignment.** An input buffer has an unaligned base. A design that keeps the low 6 bits writes to shifted addresses.
- **Freeze and resume.** Enable is cleared in the middle of a buffer. A design that loses the held byte or keeps counting delivers a short or corrupted stream.
- **Memory error.** An error is injected on the fourth byte. A design that still decrements the count, delivers the bad byte or keeps running shows a wrong remaining value or byte count.
- **Idle fallback.** Only the slot that just finished is revalidated. A design that waits only for the alternate slot hangs.
- **Other cases.** The bench also covers zero-length slots, flags cleared by writing 1s while the other flag survives, and the reset bit ignoring valid writes.

// File: rtl/dma_pp_pkg.sv
package dma_pp_pkg;
  localparam int ADDR_W    = 32;
  localparam int LEN_W     = 12;
  localparam int BYTE_W    = 8;
  localparam int PAGE_W    = 12;
  localparam int ALIGN_W   = 6;
  localparam int DESC_W    = 64;
  localparam int LEN_LSB   = 32;
  localparam int LAST_BIT  = 63;
  localparam int NUM_CTX   = 2;
  localparam int SEL_W     = 2;
  localparam int CTRL_W    = 5;
  localparam int DIAG_W    = LEN_W + 2;

  // register select codes
  localparam logic [SEL_W-1:0] SEL_DESC_A = 2'd0;
  localparam logic [SEL_W-1:0] SEL_DESC_B = 2'd1;
  localparam logic [SEL_W-1:0] SEL_CTRL   = 2'd2;
  localparam logic [SEL_W-1:0] SEL_IRQ    = 2'd3;

  // control word bit positions
  localparam int CB_DIR = 0;
  localparam int CB_EN  = 1;
  localparam int CB_RST = 2;
  localparam int CB_VB  = 3;
  localparam int CB_VA  = 4;

  typedef struct packed {
    logic              start;
    logic              run;
    logic              clear;
    logic              dir;
    logic [ADDR_W-1:0] base;
    logic [LEN_W-1:0]  len;
  } dpCmd_t;

  typedef struct packed {
    logic             drained;
    logic             errHit;
    logic [LEN_W-1:0] remaining;
  } dpStat_t;
endpackage

// File: rtl/dma_pp_datapath.sv
module dma_pp_datapath
  import dma_pp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpCmd_t            cmd,
  output dpStat_t           stat,
  output logic              memReq,
  output logic              memWrite,
  output logic [ADDR_W-1:0] memAddr,
  output logic [BYTE_W-1:0] memWrData,
  input  logic              memReady,
  input  logic [BYTE_W-1:0] memRdData,
  input  logic              memError,
  output logic              txValid,
  output logic [BYTE_W-1:0] txData,
  input  logic              txReady,
  input  logic              rxValid,
  input  logic [BYTE_W-1:0] rxData,
  output logic              rxReady
);
  logic [PAGE_W-1:0] offset;
  logic [LEN_W-1:0]  remaining;
  logic              holdFull;
  logic [BYTE_W-1:0] holdData;
  logic              memPend;
  logic [PAGE_W-1:0] pageBase;
  logic [PAGE_W-1:0] pageIdx;
  logic              moreBytes;
  logic              memAccept;
  logic              issueRd;
  logic              issueWr;
  logic              txFire;
  logic              rxFire;

  always_comb begin
    pageBase  = cmd.dir ? {cmd.base[PAGE_W-1:ALIGN_W], {ALIGN_W{1'b0}}}
                        : cmd.base[PAGE_W-1:0];
    pageIdx   = pageBase + offset;
    moreBytes = (remaining != '0);
    memAccept = memPend && memReady;
    issueRd   = cmd.run && !cmd.dir && !memPend && !holdFull && moreBytes;
    issueWr   = cmd.run &&  cmd.dir && !memPend &&  holdFull && moreBytes;
    txValid   = cmd.run && !cmd.dir && holdFull;
    rxReady   = cmd.run &&  cmd.dir && !holdFull && !memPend && moreBytes;
    txFire    = txValid && txReady;
    rxFire    = rxValid && rxReady;
  end

  assign memReq    = memPend;
  assign memWrite  = cmd.dir;
  assign memAddr   = {cmd.base[ADDR_W-1:PAGE_W], pageIdx};
  assign memWrData = holdData;
  assign txData    = holdData;

  always_comb begin
    stat.drained   = !moreBytes && !holdFull && !memPend;
    stat.errHit    = memAccept && memError;
    stat.remaining = remaining;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      offset    <= '0;
      remaining <= '0;
      holdFull  <= 1'b0;
      holdData  <= '0;
      memPend   <= 1'b0;
    end else if (cmd.clear) begin
      offset    <= '0;
      remaining <= '0;
      holdFull  <= 1'b0;
      memPend   <= 1'b0;
    end else if (cmd.start) begin
      offset    <= '0;
      remaining <= cmd.len;
      holdFull  <= 1'b0;
      memPend   <= 1'b0;
    end else begin
      if (memAccept) memPend <= 1'b0;
      if (issueRd || issueWr) memPend <= 1'b1;
      if (memAccept && !memError) begin
        offset    <= offset + PAGE_W'(1);
        remaining <= remaining - LEN_W'(1);
        if (!cmd.dir) begin
          holdData <= memRdData;
          holdFull <= 1'b1;
        end else begin
          holdFull <= 1'b0;
        end
      end
      if (txFire) holdFull <= 1'b0;
      if (rxFire) begin
        holdData <= rxData;
        holdFull <= 1'b1;
      end
    end
  end

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memReady && !cmd.clear |=> memReq && $stable(memAddr) && $stable(memWrData)); // R14
  AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memWrite |-> !txValid); // R14
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memReady && !memError && !cmd.clear && !cmd.start
      |=> stat.remaining == $past(stat.remaining) - LEN_W'(1)); // R10
  AST_ERR_NO_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memReady && memError && !cmd.clear |=> $stable(stat.remaining)); // R12
endmodule

// File: rtl/dma_pp_ctrl.sv
module dma_pp_ctrl
  import dma_pp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [SEL_W-1:0]  regSel,
  input  logic [DESC_W-1:0] regWrData,
  input  dpStat_t           stat,
  output dpCmd_t            cmd,
  output logic [CTRL_W-1:0] ctrlStatus,
  output logic [DIAG_W-1:0] diagStatus,
  output logic              irqDoneA,
  output logic              irqDoneB,
  output logic              irqMemError,
  output logic              termCount
);
  logic [NUM_CTX-1:0][ADDR_W-1:0] baseVec;
  logic [NUM_CTX-1:0][LEN_W-1:0]  lenVec;
  logic [NUM_CTX-1:0]             lastVec;

  // reserved descriptor bits are not stored
  logic unusedRsvd;
  assign unusedRsvd = ^regWrData[LAST_BIT-1:LEN_LSB+LEN_W];

  for (genvar g = 0; g < NUM_CTX; g++) begin : g_slot
    logic [ADDR_W-1:0] baseQ;
    logic [LEN_W-1:0]  lenQ;
    logic              lastQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        baseQ <= '0;
        lenQ  <= '0;
        lastQ <= 1'b0;
      end else if (regWrEn && regSel == SEL_W'(g)) begin
        baseQ <= regWrData[ADDR_W-1:0];
        lenQ  <= regWrData[LEN_LSB+LEN_W-1:LEN_LSB];
        lastQ <= regWrData[LAST_BIT];
      end
    end
    assign baseVec[g] = baseQ;
    assign lenVec[g]  = lenQ;
    assign lastVec[g] = lastQ;
  end

  logic               dirR, enR, rstR, busy, curCtx, tcR, errIrq;
  logic [NUM_CTX-1:0] validR, validNext, doneIrq, doneNext;
  logic               wrCtrl, wrClr, startNow, doneNow, startCtx, ctxSel;

  always_comb begin
    wrCtrl   = regWrEn && (regSel == SEL_CTRL);
    wrClr    = regWrEn && (regSel == SEL_IRQ);
    startCtx = validR[curCtx] ? curCtx : ~curCtx;
    startNow = !busy && enR && !rstR && (|validR);
    doneNow  = busy && enR && !rstR && stat.drained;
    ctxSel   = busy ? curCtx : startCtx;

    validNext = validR;
    if (rstR) validNext = '0;
    else if (doneNow) validNext[curCtx] = 1'b0;
    if (wrCtrl && !regWrData[CB_RST])
      validNext = validNext | {regWrData[CB_VB], regWrData[CB_VA]};

    doneNext = doneIrq;
    if (wrClr) doneNext = doneNext & ~regWrData[NUM_CTX-1:0];
    if (doneNow) doneNext[curCtx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirR    <= 1'b0;
      enR     <= 1'b0;
      rstR    <= 1'b0;
      busy    <= 1'b0;
      curCtx  <= 1'b0;
      tcR     <= 1'b0;
      errIrq  <= 1'b0;
      validR  <= '0;
      doneIrq <= '0;
    end else begin
      validR  <= validNext;
      doneIrq <= doneNext;
      tcR     <= doneNow && lastVec[curCtx];
      if (rstR) begin
        busy   <= 1'b0;
        curCtx <= 1'b0;
      end else if (startNow) begin
        busy   <= 1'b1;
        curCtx <= startCtx;
      end else if (doneNow) begin
        busy   <= 1'b0;
        curCtx <= ~curCtx;
      end
      if (wrClr && regWrData[NUM_CTX]) errIrq <= 1'b0;
      if (stat.errHit) begin
        errIrq <= 1'b1;
        enR    <= 1'b0;
      end
      if (wrCtrl) begin
        dirR <= regWrData[CB_DIR];
        enR  <= regWrData[CB_EN];
        rstR <= regWrData[CB_RST];
      end
    end
  end

  always_comb begin
    cmd.start = startNow;
    cmd.run   = busy && enR && !rstR;
    cmd.clear = rstR;
    cmd.dir   = dirR;
    cmd.base  = baseVec[ctxSel];
    cmd.len   = lenVec[ctxSel];
  end

  assign ctrlStatus  = {validR[0], validR[1], rstR, enR, dirR};
  assign diagStatus  = {stat.remaining, busy && enR, curCtx};
  assign irqDoneA    = doneIrq[0];
  assign irqDoneB    = doneIrq[1];
  assign irqMemError = errIrq;
  assign termCount   = tcR;

  AST_TC_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    termCount |=> !termCount); // R5
  AST_DONE_CLEARS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    doneNow && !wrCtrl |=> !validR[$past(curCtx)]); // R6
  AST_DONE_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    doneNow |=> doneIrq[$past(curCtx)]); // R11
  AST_CTX_SWAP: assert property (@(posedge clk) disable iff (!rstN)
    doneNow |=> curCtx != $past(curCtx)); // R7
  AST_ERR_STOPS: assert property (@(posedge clk) disable iff (!rstN)
    stat.errHit && !wrCtrl |=> !enR && irqMemError); // R12
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    rstR && !wrCtrl |=> !busy && validR == '0 && !cmd.run); // R9
endmodule

// File: rtl/dma_pingpong_chan.sv
module dma_pingpong_chan
  import dma_pp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [SEL_W-1:0]  regSel,
  input  logic [DESC_W-1:0] regWrData,
  output logic [CTRL_W-1:0] ctrlStatus,
  output logic [DIAG_W-1:0] diagStatus,
  output logic              irqDoneA,
  output logic              irqDoneB,
  output logic              irqMemError,
  output logic              termCount,
  output logic              memReq,
  output logic              memWrite,
  output logic [ADDR_W-1:0] memAddr,
  output logic [BYTE_W-1:0] memWrData,
  input  logic              memReady,
  input  logic [BYTE_W-1:0] memRdData,
  input  logic              memError,
  output logic              txValid,
  output logic [BYTE_W-1:0] txData,
  input  logic              txReady,
  input  logic              rxValid,
  input  logic [BYTE_W-1:0] rxData,
  output logic              rxReady
);
  dpCmd_t  cmd;
  dpStat_t stat;

  dma_pp_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .regWrEn     (regWrEn),
    .regSel      (regSel),
    .regWrData   (regWrData),
    .stat        (stat),
    .cmd         (cmd),
    .ctrlStatus  (ctrlStatus),
    .diagStatus  (diagStatus),
    .irqDoneA    (irqDoneA),
    .irqDoneB    (irqDoneB),
    .irqMemError (irqMemError),
    .termCount   (termCount)
  );

  dma_pp_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cmd       (cmd),
    .stat      (stat),
    .memReq    (memReq),
    .memWrite  (memWrite),
    .memAddr   (memAddr),
    .memWrData (memWrData),
    .memReady  (memReady),
    .memRdData (memRdData),
    .memError  (memError),
    .txValid   (txValid),
    .txData    (txData),
    .txReady   (txReady),
    .rxValid   (rxValid),
    .rxData    (rxData),
    .rxReady   (rxReady)
  );
endmodule

// File: tb/dma_pingpong_chan_tb.sv
module dma_pingpong_chan_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  typedef struct packed {
    logic        dir;
    logic [11:0] base;
    logic [11:0] len;
    logic        last;
  } vec_t;

  localparam int NVEC = 5;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 12'h010, 12'd8,  1'b1},   // plain output, last
    '{1'b0, 12'hFF0, 12'd32, 1'b0},   // output across page end
    '{1'b1, 12'h1A5, 12'd10, 1'b1},   // input, unaligned base
    '{1'b1, 12'h2C0, 12'd20, 1'b0},   // input, aligned base
    '{1'b0, 12'h005, 12'd0,  1'b1}    // zero length
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regSel = '0;
  logic [63:0] regWrData = '0;
  logic [4:0]  ctrlStatus;
  logic [13:0] diagStatus;
  logic        irqDoneA, irqDoneB, irqMemError, termCount;
  logic        memReq, memWrite, memReady, memError;
  logic [31:0] memAddr;
  logic [7:0]  memWrData, memRdData, txData, rxData;
  logic        txValid, txReady, rxValid, rxReady;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int sinkCnt = 0;
  int srcIdx = 0;
  int srcLimit = 0;
  int tcCnt = 0;
  logic        errArm = 1'b0;
  logic [31:0] errAddr = '0;
  logic [7:0]  memArr  [1024];
  logic [7:0]  sinkLog [512];
  logic [7:0]  srcBuf  [256];

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_pingpong_chan u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel), .regWrData(regWrData),
    .ctrlStatus(ctrlStatus), .diagStatus(diagStatus), .irqDoneA(irqDoneA),
    .irqDoneB(irqDoneB), .irqMemError(irqMemError), .termCount(termCount),
    .memReq(memReq), .memWrite(memWrite), .memAddr(memAddr), .memWrData(memWrData),
    .memReady(memReady), .memRdData(memRdData), .memError(memError),
    .txValid(txValid), .txData(txData), .txReady(txReady),
    .rxValid(rxValid), .rxData(rxData), .rxReady(rxReady)
  );

  // memory, sink and source models, with periodic stalls
  assign memReady  = memReq && (cyc % 3 != 1);
  assign memError  = memReq && errArm && (memAddr == errAddr);
  assign memRdData = memArr[memAddr[9:0]];
  assign txReady   = (cyc % 4 != 0);
  assign rxValid   = (srcIdx < srcLimit);
  assign rxData    = srcBuf[srcIdx % 256];

  function automatic logic [7:0] initByte(input int idx);
    return 8'(idx * 7 + 3);
  endfunction

  initial for (int i = 0; i < 1024; i++) memArr[i] = initByte(i);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (memReq && memReady && memWrite && !memError) memArr[memAddr[9:0]] <= memWrData;
    if (txValid && txReady) begin
      sinkLog[sinkCnt % 512] <= txData;
      sinkCnt <= sinkCnt + 1;
    end
    if (rxValid && rxReady) srcIdx <= srcIdx + 1;
    if (termCount) tcCnt <= tcCnt + 1;
    if (cyc == WATCHDOG) begin
      errors = errors + 1;
      $display("FAIL watchdog R1 actual=%0d expected=<%0d cycles", cyc, WATCHDOG);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic check(input logic ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic writeReg(input logic [1:0] sel, input logic [63:0] data);
    @(negedge clk);
    regWrEn = 1'b1; regSel = sel; regWrData = data;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  function automatic logic [63:0] desc(input logic last, input logic [11:0] len, input logic [31:0] base);
    return {last, 19'b0, len, base};
  endfunction

  task automatic waitFlag(input int which, input int limit, output logic ok);
    ok = 1'b0;
    for (int i = 0; i < limit && !ok; i++) begin
      @(negedge clk);
      ok = (which == 0) ? irqDoneA : (which == 1) ? irqDoneB : irqMemError;
    end
  endtask

  task automatic chanReset();
    writeReg(2'd2, 64'(5'b00100));
    writeReg(2'd2, 64'(5'b00000));
    writeReg(2'd3, 64'd7);
  endtask

  initial begin
    logic ok;
    int sinkBase, tcBase, srcStart, bad, snapSink;
    logic [13:0] snapDiag;

    repeat (3) @(negedge clk);
    // R1 reset state
    check(ctrlStatus == 0 && diagStatus == 0, "R1 status after reset", {ctrlStatus, diagStatus}, 0);
    check(!irqDoneA && !irqDoneB && !irqMemError && !termCount && !memReq,
          "R1 outputs idle after reset", {irqDoneA, irqDoneB, irqMemError, termCount, memReq}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // table walk: one slot-A transfer per vector
    for (int v = 0; v < NVEC; v++) begin
      chanReset();
      sinkBase = sinkCnt; tcBase = tcCnt; srcStart = srcIdx;
      if (VECS[v].dir) begin
        for (int k = 0; k < VECS[v].len; k++) srcBuf[(srcStart + k) % 256] = 8'(k * 13 + v * 31 + 1);
        srcLimit = srcStart + int'(VECS[v].len);
      end
      writeReg(2'd0, desc(VECS[v].last, VECS[v].len, {20'h0, VECS[v].base}));
      writeReg(2'd2, 64'({4'b1001, VECS[v].dir}));
      waitFlag(0, 4000, ok);
      check(ok, "R11 R13 slot A done flag", ok, 1);
      repeat (4) @(negedge clk);
      bad = 0;
      if (!VECS[v].dir) begin
        check(sinkCnt - sinkBase == int'(VECS[v].len), "R2 R13 output byte count",
              sinkCnt - sinkBase, VECS[v].len);
        for (int k = 0; k < VECS[v].len; k++) begin
          logic [11:0] a;
          a = VECS[v].base + 12'(k);
          if (sinkLog[(sinkBase + k) % 512] != initByte(int'(a[9:0]))) bad++;
        end
        check(bad == 0, "R2 R4 R14 output data in address order", bad, 0);
      end else begin
        check(srcIdx - srcStart == int'(VECS[v].len), "R3 input byte count",
              srcIdx - srcStart, VECS[v].len);
        for (int k = 0; k < VECS[v].len; k++) begin
          logic [11:0] a;
          a = {VECS[v].base[11:6], 6'b0} + 12'(k);
          if (memArr[a[9:0]] != srcBuf[(srcStart + k) % 256]) bad++;
        end
        check(bad == 0, "R3 input data at aligned base", bad, 0);
      end
      check(tcCnt - tcBase == int'(VECS[v].last), "R5 terminal count pulses", tcCnt - tcBase, VECS[v].last);
      check(diagStatus[13:1] == 0, "R10 diag idle after completion", diagStatus[13:1], 0);
    end

    // ping-pong: A then B
    chanReset();
    sinkBase = sinkCnt; tcBase = tcCnt;
    writeReg(2'd0, desc(1'b0, 12'd5, 32'h200));
    writeReg(2'd1, desc(1'b1, 12'd7, 32'h300));
    writeReg(2'd2, 64'(5'b11000));
    check(ctrlStatus == 5'b11000, "R6 valid bits at 4 and 3", ctrlStatus, 5'b11000);
    writeReg(2'd2, 64'(5'b00010));
    waitFlag(1, 4000, ok);
    check(ok && irqDoneA, "R7 slot B follows slot A", {irqDoneA, ok}, 2'b11);
    repeat (4) @(negedge clk);
    bad = 0;
    for (int k = 0; k < 12; k++) begin
      logic [7:0] e;
      e = (k < 5) ? initByte(32'h200 + k) : initByte(32'h300 + k - 5);
      if (sinkLog[(sinkBase + k) % 512] != e) bad++;
    end
    check(sinkCnt - sinkBase == 12 && bad == 0, "R7 ping-pong stream order", bad, 0);
    check(ctrlStatus[4:3] == 2'b00, "R6 hardware clears valid bits", ctrlStatus[4:3], 0);
    check(tcCnt - tcBase == 1, "R5 only last slot pulses", tcCnt - tcBase, 1);
    check(diagStatus[0] == 1'b0, "R10 slot in use back to A", diagStatus[0], 0);

    // R11 clearing by writing 1s
    writeReg(2'd3, 64'd1);
    check(!irqDoneA && irqDoneB, "R11 clear A keeps B", {irqDoneA, irqDoneB}, 2'b01);

    // R7 fallback: only the just-finished slot revalidated
    chanReset();
    writeReg(2'd0, desc(1'b0, 12'd2, 32'h010));
    writeReg(2'd2, 64'(5'b10010));
    waitFlag(0, 2000, ok);
    writeReg(2'd3, 64'd7);
    sinkBase = sinkCnt;
    writeReg(2'd0, desc(1'b0, 12'd3, 32'h020));
    writeReg(2'd2, 64'(5'b10010));
    waitFlag(0, 2000, ok);
    repeat (4) @(negedge clk);
    check(ok && sinkCnt - sinkBase == 3, "R7 idle falls back to same slot", sinkCnt - sinkBase, 3);
    check(diagStatus[0] == 1'b1, "R7 R10 slot pointer moved to B", diagStatus[0], 1);

    // R9 reset hold mid-transfer
    writeReg(2'd3, 64'd7);
    writeReg(2'd0, desc(1'b0, 12'd30, 32'h080));
    writeReg(2'd2, 64'(5'b10010));
    sinkBase = sinkCnt;
    for (int i = 0; i < 3000 && sinkCnt - sinkBase < 5; i++) @(negedge clk);
    writeReg(2'd2, 64'(5'b10110));
    repeat (3) @(negedge clk);
    snapSink = sinkCnt;
    check(ctrlStatus == 5'b00110 && diagStatus == 0, "R9 reset hold clears valid and diag",
          {ctrlStatus, diagStatus}, {5'b00110, 14'd0});
    repeat (20) @(negedge clk);
    check(!memReq && sinkCnt == snapSink && !irqDoneA, "R9 no traffic in reset hold", sinkCnt - snapSink, 0);
    writeReg(2'd2, 64'd0);

    // R8 freeze and resume
    writeReg(2'd3, 64'd7);
    sinkBase = sinkCnt;
    writeReg(2'd0, desc(1'b0, 12'd40, 32'h040));
    writeReg(2'd2, 64'(5'b10010));
    for (int i = 0; i < 3000 && sinkCnt - sinkBase < 10; i++) @(negedge clk);
    writeReg(2'd2, 64'(5'b10000));
    repeat (6) @(negedge clk);
    snapSink = sinkCnt; snapDiag = diagStatus;
    repeat (30) @(negedge clk);
    check(sinkCnt == snapSink && diagStatus == snapDiag && !memReq, "R8 frozen channel holds",
          sinkCnt - snapSink, 0);
    check(ctrlStatus[4] && !diagStatus[1], "R8 R10 valid kept, not running", {ctrlStatus[4], diagStatus[1]}, 2'b10);
    writeReg(2'd2, 64'(5'b10010));
    waitFlag(0, 4000, ok);
    repeat (4) @(negedge clk);
    bad = 0;
    for (int k = 0; k < 40; k++)
      if (sinkLog[(sinkBase + k) % 512] != initByte(32'h040 + k)) bad++;
    check(ok && sinkCnt - sinkBase == 40 && bad == 0, "R8 resume completes intact", bad, 0);

    // R12 memory error on fourth byte
    chanReset();
    errAddr = 32'h103; errArm = 1'b1;
    sinkBase = sinkCnt;
    writeReg(2'd0, desc(1'b0, 12'd16, 32'h100));
    writeReg(2'd2, 64'(5'b10010));
    waitFlag(2, 3000, ok);
    repeat (10) @(negedge clk);
    check(ok && !ctrlStatus[1], "R12 error clears enable", ctrlStatus[1], 0);
    check(sinkCnt - sinkBase == 3, "R12 failed byte not delivered", sinkCnt - sinkBase, 3);
    check(diagStatus[13:2] == 12'd13, "R12 R10 count not decremented", diagStatus[13:2], 13);
    errArm = 1'b0;
    writeReg(2'd3, 64'd4);
    check(!irqMemError, "R11 error flag cleared by bit 2", irqMemError, 0);
    chanReset();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule